// File: doc/BRIEF.md
# Soft-Error Detection Method Arbiter

This block sits in the decode stage of a core. For each ALU instruction it picks one way to check that instruction for transient faults. It looks at three things: how many cycles of slack the instruction is expected to have, a programmable slack limit, and the two source operand values.

The methods are tried in a fixed order, and the first whose condition holds wins:

1. **Re-execution in the idle cycles.** Chosen when the slack is long enough.
2. **Duplicated narrow operands on the same unit.** Chosen when both operands fit in the lower half of the word.
3. **Residue checking in the two freed top bits.** Chosen when both operands leave their two highest bits clear.
4. **A copy of the instruction on an idle neighbour core.** Chosen in every other case.

The result comes out as a registered one-hot vector. The block also raises a flag whenever the neighbour core is needed, and keeps one saturating usage counter per method.

In dynamic mode the incoming slack is a run-time prediction. That prediction is coarsened to one of three values before it is compared with the limit.

Top module: `detect_arbiter`

## Requirements
- R1: One cycle after `instValid` is high, `choiceValid` is high and `choice` has exactly one bit set. Bit 0 is re-execution, bit 1 is narrow-operand duplication, bit 2 is residue checking and bit 3 is neighbour-core copy. After a cycle with `instValid` low, `choiceValid` is low and `choice` is 0.
- R2: Re-execution (bit 0) is chosen when the effective slack is strictly greater than the limit. A slack equal to the limit does not qualify.
- R3: When re-execution does not qualify and both operands have all bits in the upper half of the word at zero, narrow-operand duplication (bit 1) is chosen.
- R4: When neither earlier method qualifies and both operands have their two most significant bits at zero, residue checking (bit 2) is chosen.
- R5: In all remaining cases the neighbour-core copy (bit 3) is chosen. `needNeighbor` is high exactly in the cycles that present this choice.
- R6: The slack limit resets to 5. A write through `thrWrEn` and `thrWrData` applies to instructions presented in later cycles. An instruction presented in the same cycle as the write still uses the old limit.
- R7: With `dynMode` high, the slack is first mapped before the comparison: 0 or 1 becomes 1, 2 or 3 becomes 2, and 4 or more becomes 4.
- R8: Each method has a usage counter that resets to 0. The counter advances by one in the same cycle that its method appears on `choice`, and holds in every other cycle.
- R9: A usage counter that reaches all ones stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An ALU instruction is presented this cycle |
| dynMode | input | 1 | Slack is a run-time prediction; coarsen it before comparing |
| slack | input | SLACK_W | Estimated slack in cycles |
| opA | input | DATA_W | First source operand |
| opB | input | DATA_W | Second source operand |
| thrWrEn | input | 1 | Load a new slack limit |
| thrWrData | input | SLACK_W | New slack limit |
| choice | output | 4 | One-hot detection method |
| choiceValid | output | 1 | `choice` holds a decision |
| needNeighbor | output | 1 | An idle neighbour core is required |
| cntTemporal | output | CNT_W | Re-execution usage count |
| cntSmall | output | CNT_W | Narrow-operand usage count |
| cntResidue | output | CNT_W | Residue usage count |
| cntSpatial | output | CNT_W | Neighbour-core usage count |

## Verification
Every decision, the `needNeighbor` flag and the counter updates are due exactly one clock edge after the instruction is presented. A limit write is seen by instructions presented from the following edge onward. The driver applies inputs on the falling edge and queues the expected method together with all four expected counter values. The monitor reads the registered outputs on the next falling edge, so each queued entry is matched to the decision made at the single rising edge between the two.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
  localparam int NUM_METHODS = 4;
  localparam int M_TEMPORAL  = 0;
  localparam int M_SMALL     = 1;
  localparam int M_RESIDUE   = 2;
  localparam int M_SPATIAL   = 3;

  // Operand and slack tests, datapath -> control
  typedef struct packed {
    logic slackAbove;
    logic aNarrow;
    logic bNarrow;
    logic aTopClear;
    logic bTopClear;
  } arb_flags_t;

  // Strobes, control -> datapath
  typedef struct packed {
    logic                   load;
    logic [NUM_METHODS-1:0] pick;
  } arb_strobe_t;
endpackage

// File: rtl/arb_control.sv
`timescale 1ns/1ps
module arb_control
  import arb_pkg::*;
(
  input  logic        instValid,
  input  arb_flags_t  flags,
  output arb_strobe_t strobe
);
  always_comb begin
    strobe.load = instValid;
    strobe.pick = '0;
    if (flags.slackAbove)
      strobe.pick[M_TEMPORAL] = 1'b1;
    else if (flags.aNarrow && flags.bNarrow)
      strobe.pick[M_SMALL] = 1'b1;
    else if (flags.aTopClear && flags.bTopClear)
      strobe.pick[M_RESIDUE] = 1'b1;
    else
      strobe.pick[M_SPATIAL] = 1'b1;
  end
endmodule

// File: rtl/arb_datapath.sv
`timescale 1ns/1ps
module arb_datapath
  import arb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SLACK_W  = 6,
  parameter int CNT_W    = 8,
  parameter int THR_INIT = 5
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 thrWrEn,
  input  logic [SLACK_W-1:0]                   thrWrData,
  input  logic                                 dynMode,
  input  logic [SLACK_W-1:0]                   slack,
  input  logic [DATA_W-1:0]                    opA,
  input  logic [DATA_W-1:0]                    opB,
  input  arb_strobe_t                          strobe,
  output arb_flags_t                           flags,
  output logic [SLACK_W-1:0]                   thrQ,
  output logic [NUM_METHODS-1:0]               choice,
  output logic                                 choiceValid,
  output logic                                 needNeighbor,
  output logic [NUM_METHODS-1:0][CNT_W-1:0]    usage
);
  localparam int HALF = DATA_W / 2;
  localparam logic [SLACK_W-1:0] DYN_HI  = SLACK_W'(4);
  localparam logic [SLACK_W-1:0] DYN_MID = SLACK_W'(2);
  localparam logic [SLACK_W-1:0] DYN_LO  = SLACK_W'(1);
  localparam logic [CNT_W-1:0]   CNT_MAX = '1;

  logic [SLACK_W-1:0] effSlack;
  logic [CNT_W-1:0]   cntQ [NUM_METHODS];

  // Coarsen a predicted slack to 1, 2 or 4
  always_comb begin
    if (!dynMode)                effSlack = slack;
    else if (slack >= DYN_HI)    effSlack = DYN_HI;
    else if (slack >= DYN_MID)   effSlack = DYN_MID;
    else                         effSlack = DYN_LO;
  end

  always_comb begin
    flags.slackAbove = effSlack > thrQ;
    flags.aNarrow    = ~|opA[DATA_W-1:HALF];
    flags.bNarrow    = ~|opB[DATA_W-1:HALF];
    flags.aTopClear  = ~|opA[DATA_W-1:DATA_W-2];
    flags.bTopClear  = ~|opB[DATA_W-1:DATA_W-2];
  end

  always_ff @(posedge clk) begin
    if (!rstN)        thrQ <= SLACK_W'(THR_INIT);
    else if (thrWrEn) thrQ <= thrWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      choice       <= '0;
      choiceValid  <= 1'b0;
      needNeighbor <= 1'b0;
    end else begin
      choice       <= strobe.load ? strobe.pick : '0;
      choiceValid  <= strobe.load;
      needNeighbor <= strobe.load & strobe.pick[M_SPATIAL];
    end
  end

  for (genvar k = 0; k < NUM_METHODS; k++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN)
        cntQ[k] <= '0;
      else if (strobe.load && strobe.pick[k] && cntQ[k] != CNT_MAX)
        cntQ[k] <= cntQ[k] + 1'b1;
    end
    assign usage[k] = cntQ[k];
  end
endmodule

// File: rtl/detect_arbiter.sv
`timescale 1ns/1ps
module detect_arbiter
  import arb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SLACK_W  = 6,
  parameter int CNT_W    = 8,
  parameter int THR_INIT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instValid,
  input  logic               dynMode,
  input  logic [SLACK_W-1:0] slack,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic               thrWrEn,
  input  logic [SLACK_W-1:0] thrWrData,
  output logic [3:0]         choice,
  output logic               choiceValid,
  output logic               needNeighbor,
  output logic [CNT_W-1:0]   cntTemporal,
  output logic [CNT_W-1:0]   cntSmall,
  output logic [CNT_W-1:0]   cntResidue,
  output logic [CNT_W-1:0]   cntSpatial
);
  arb_flags_t                              flags;
  arb_strobe_t                             strobe;
  logic [SLACK_W-1:0]                      thrQ;
  logic [NUM_METHODS-1:0][CNT_W-1:0]       usage;

  arb_control u_ctrl (
    .instValid (instValid),
    .flags     (flags),
    .strobe    (strobe)
  );

  arb_datapath #(
    .DATA_W(DATA_W), .SLACK_W(SLACK_W), .CNT_W(CNT_W), .THR_INIT(THR_INIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .thrWrEn      (thrWrEn),
    .thrWrData    (thrWrData),
    .dynMode      (dynMode),
    .slack        (slack),
    .opA          (opA),
    .opB          (opB),
    .strobe       (strobe),
    .flags        (flags),
    .thrQ         (thrQ),
    .choice       (choice),
    .choiceValid  (choiceValid),
    .needNeighbor (needNeighbor),
    .usage        (usage)
  );

  assign cntTemporal = usage[M_TEMPORAL];
  assign cntSmall    = usage[M_SMALL];
  assign cntResidue  = usage[M_RESIDUE];
  assign cntSpatial  = usage[M_SPATIAL];
endmodule

// File: rtl/arb_checker.sv
`timescale 1ns/1ps
module arb_checker #(
  parameter int SLACK_W = 6,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               instValid,
  input logic               dynMode,
  input logic [SLACK_W-1:0] slack,
  input logic [SLACK_W-1:0] thrQ,
  input logic [3:0]         choice,
  input logic               choiceValid,
  input logic               needNeighbor,
  input logic [CNT_W-1:0]   cntTemporal,
  input logic [CNT_W-1:0]   cntSpatial
);
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rstN)
    choiceValid |-> $countones(choice) == 1);
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !choiceValid |-> choice == 4'b0000);
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> choiceValid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |=> !choiceValid);
  a_r2_above_limit: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !dynMode && slack > thrQ) |=> choice[0]);
  a_r2_equal_not_temporal: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !dynMode && slack == thrQ) |=> !choice[0]);
  a_r5_neighbor_flag: assert property (@(posedge clk) disable iff (!rstN)
    needNeighbor |-> (choiceValid && choice[3]));
  a_r5_neighbor_raised: assert property (@(posedge clk) disable iff (!rstN)
    (choiceValid && choice[3]) |-> needNeighbor);
  a_r8_temporal_moves_on_pick: assert property (@(posedge clk) disable iff (!rstN)
    (cntTemporal != $past(cntTemporal)) |-> (choiceValid && choice[0]));
  a_r8_spatial_moves_on_pick: assert property (@(posedge clk) disable iff (!rstN)
    (cntSpatial != $past(cntSpatial)) |-> (choiceValid && choice[3]));
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    cntSpatial >= $past(cntSpatial));
endmodule

bind detect_arbiter arb_checker #(.SLACK_W(SLACK_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .instValid    (instValid),
  .dynMode      (dynMode),
  .slack        (slack),
  .thrQ         (thrQ),
  .choice       (choice),
  .choiceValid  (choiceValid),
  .needNeighbor (needNeighbor),
  .cntTemporal  (cntTemporal),
  .cntSpatial   (cntSpatial)
);

// File: tb/test_detect_arbiter.sv
`timescale 1ns/1ps
module test_detect_arbiter;
  localparam int DW = 32;
  localparam int SW = 6;
  localparam int CW = 4;

  typedef struct packed {
    logic [3:0]         pick;
    logic [3:0][CW-1:0] cnt;
  } item_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instValid = 1'b0;
  logic          dynMode = 1'b0;
  logic [SW-1:0] slack = '0;
  logic [DW-1:0] opA = '0;
  logic [DW-1:0] opB = '0;
  logic          thrWrEn = 1'b0;
  logic [SW-1:0] thrWrData = '0;
  logic [3:0]    choice;
  logic          choiceValid;
  logic          needNeighbor;
  logic [CW-1:0] cntTemporal, cntSmall, cntResidue, cntSpatial;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t expQ[$];
  logic [SW-1:0] mThr = SW'(5);
  logic [CW-1:0] mCnt [4] = '{default: '0};

  always #4 clk = ~clk;

  detect_arbiter #(.DATA_W(DW), .SLACK_W(SW), .CNT_W(CW)) i_detect_arbiter (
    .clk(clk), .rstN(rstN), .instValid(instValid), .dynMode(dynMode),
    .slack(slack), .opA(opA), .opB(opB), .thrWrEn(thrWrEn), .thrWrData(thrWrData),
    .choice(choice), .choiceValid(choiceValid), .needNeighbor(needNeighbor),
    .cntTemporal(cntTemporal), .cntSmall(cntSmall),
    .cntResidue(cntResidue), .cntSpatial(cntSpatial)
  );

  function automatic string tagFor(logic [3:0] p);
    case (p)
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0100: return "R4";
      default: return "R5";
    endcase
  endfunction

  // R7 slack coarsening, R2..R5 priority
  function automatic logic [3:0] model(logic dyn, logic [SW-1:0] s, logic [SW-1:0] thr,
                                       logic [DW-1:0] a, logic [DW-1:0] b);
    logic [SW-1:0] e;
    e = !dyn ? s : (s >= 4) ? SW'(4) : (s >= 2) ? SW'(2) : SW'(1);
    if (e > thr)                               return 4'b0001;
    if (a[DW-1:DW/2] == 0 && b[DW-1:DW/2] == 0) return 4'b0010;
    if (a[DW-1:DW-2] == 0 && b[DW-1:DW-2] == 0) return 4'b0100;
    return 4'b1000;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic drive(logic v, logic dyn, logic [SW-1:0] s, logic [DW-1:0] a,
                       logic [DW-1:0] b, logic wr = 1'b0, logic [SW-1:0] wd = '0);
    item_t it;
    @(negedge clk);
    instValid = v; dynMode = dyn; slack = s; opA = a; opB = b;
    thrWrEn = wr; thrWrData = wd;
    if (v) begin
      it.pick = model(dyn, s, mThr, a, b);
      for (int k = 0; k < 4; k++) begin
        if (it.pick[k] && mCnt[k] != '1) mCnt[k] = mCnt[k] + 1'b1;
        it.cnt[k] = mCnt[k];
      end
      expQ.push_back(it);
    end
    if (wr) mThr = wd;   // applies from the next instruction on (R6)
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, '0, '0);
  endtask

  // Monitor: results are due on the falling edge after the deciding rising edge
  always @(negedge clk) begin
    if (rstN) begin
      if (choiceValid) begin
        if (expQ.size() == 0) check("R1 unexpected result", 32'(choice), 32'h0);
        else begin
          item_t e;
          e = expQ.pop_front();
          check({tagFor(e.pick), " choice"}, 32'(choice), 32'(e.pick));
          check("R5 needNeighbor", 32'(needNeighbor), 32'(e.pick[3]));
          check("R8/R9 cntTemporal", 32'(cntTemporal), 32'(e.cnt[0]));
          check("R8/R9 cntSmall", 32'(cntSmall), 32'(e.cnt[1]));
          check("R8/R9 cntResidue", 32'(cntResidue), 32'(e.cnt[2]));
          check("R8/R9 cntSpatial", 32'(cntSpatial), 32'(e.cnt[3]));
        end
      end else begin
        check("R1 idle choice", 32'({choice, needNeighbor}), 32'h0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 reset state of counters, R1 outputs idle
    check("R8 reset counters", 32'({cntTemporal, cntSmall, cntResidue, cntSpatial}), 32'h0);
    check("R1 reset outputs", 32'({choice, choiceValid, needNeighbor}), 32'h0);
    // R6 reset limit 5: slack 6 above, slack 5 equal (R2)
    drive(1, 0, 6, 32'hFFFF_0000, 32'hFFFF_0000);
    drive(1, 0, 5, 32'h0000_1234, 32'h0000_00FF);       // R3
    drive(1, 0, 5, 32'h1234_5678, 32'h0000_0003);       // R4
    drive(1, 0, 0, 32'h3FFF_FFFF, 32'h2000_0000);       // R4 both top clear
    drive(1, 0, 5, 32'hC000_0000, 32'h0000_0001);       // R5
    drive(1, 0, 2, 32'h0000_0001, 32'h4000_0000);       // R5
    idle(2);                                            // R1 idle
    // R6 write in same cycle as instruction: old limit 5 used
    drive(1, 0, 3, 32'h8000_0000, 32'h0, 1'b1, SW'(2));
    drive(1, 0, 3, 32'h8000_0000, 32'h0);               // now 3 > 2: R2
    drive(1, 0, 2, 32'h0000_0005, 32'h0000_0006);       // equal: R3
    // R7 dynamic mode with limit 2
    drive(1, 1, 3, 32'hFFFF_FFFF, 32'h0);               // 3->2, equal: R5
    drive(1, 1, 7, 32'hFFFF_FFFF, 32'h0);               // 7->4: R2
    drive(1, 1, 0, 32'h0000_0010, 32'h0);               // 0->1: R3
    drive(1, 1, 63, 32'h0, 32'h0, 1'b1, SW'(3));        // 63->4 > 2: R2
    drive(1, 1, 3, 32'h0, 32'h0);                       // 3->2, limit 3: R3
    drive(1, 0, 4, 32'h0, 32'h0);                       // non-dyn 4 > 3: R2
    idle(1);
    // R9 saturation of the residue counter
    for (int i = 0; i < 20; i++) drive(1, 0, 0, 32'h0100_0000 + i, 32'h0000_0002);
    // mixed patterns
    drive(1'b0, 1'b0, '0, '0, '0, 1'b1, SW'(5));
    for (int i = 0; i < 80; i++) begin
      logic [DW-1:0] a, b;
      a = $urandom;
      b = $urandom;
      case (i % 4)
        0: begin a[DW-1:DW/2] = '0; b[DW-1:DW/2] = '0; end
        1: begin a[DW-1:DW-2] = '0; b[DW-1:DW-2] = '0; end
        default: ;
      endcase
      drive(1, 1'($urandom % 2), SW'($urandom % 10), a, b);
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    check("R1 all results seen", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule